// File: doc/BRIEF.md
# Confidence-Gated Indirect Target Cache

This block predicts where an indirect jump or call will go. A fetch-side lookup presents the branch PC. The block XORs that PC with its own global history of recent conditional-branch outcomes. The low bits of the result pick a set of a set-associative table, and the remaining bits are compared against the stored tags. One cycle later the block returns a response: whether an entry matched, the stored target, and an "issue" flag. The issue flag is raised only when that entry's confidence counter has reached a threshold supplied on a pin. The response also returns the history value that was used, so the caller can hand it back when the branch resolves.

At resolve time an update presents the PC, the returned history and the real target. On a hit the entry's confidence counter is raised if the target was correct. If the target was wrong, the counter is cleared and the target is overwritten. On a miss, a way of the set is claimed for the new tag and target. Each entry also carries a saturating age counter. The choice of way to replace is set by a mode pin: oldest entry, least confident entry, or least confident with age as tie-break.

The lookup side is a valid/ready stream with a registered response. The response is also valid/ready. While a response is held back it stays frozen, and no new lookup is taken. Updates and history shifts are plain strobes that are accepted in every cycle.

Top module: `itc_predictor`

## Requirements
- R1: After reset every entry is invalid, the history register is zero, `rsp_valid` is low and `lk_ready` is high, so every lookup misses.
- R2: The lookup key is `lk_pc` XOR the history zero-extended to the PC width. Key bits [SET_W-1:0] select the set and the upper key bits form the tag. Updates form their key the same way from `up_pc` and `up_hist`.
- R3: A lookup that matches no valid way returns `rsp_hit`=0, `rsp_issue`=0 and `rsp_target`=0. An update that misses allocates a way with the new tag and target and a confidence of 0.
- R4: A lookup that matches returns the stored target with `rsp_hit`=1. `rsp_issue` is 1 exactly when the entry's confidence is at least `conf_thresh`, with the threshold taken in the cycle the lookup is accepted.
- R5: An update that hits with an equal target raises confidence by one, saturating at all-ones. An update that hits with a different target overwrites the target and clears confidence to 0.
- R6: Each cycle with `br_valid`=1 shifts `br_taken` into bit 0 of the GHR_W-bit history, and the oldest bit is dropped. Otherwise the history holds its value.
- R7: An allocating update fills the lowest-numbered invalid way of its set before it evicts any valid entry.
- R8: Every update sets the age of the way it writes to 0 and raises the age of every other valid way in that set by one, saturating. With `repl_mode`=0 the victim is the way with the greatest age; on a tie the lowest index wins.
- R9: With `repl_mode`=1 the victim is the way with the smallest confidence; on a tie the lowest index wins.
- R10: With `repl_mode`=2 or 3 the victim is the way with the smallest confidence. Among those, the greatest age wins, and then the lowest index.
- R11: When an update and a lookup address the same set in the same cycle, the lookup sees the set as already updated.
- R12: `lk_ready` is high when no response is held or `rsp_ready` is high. While `rsp_valid`=1 and `rsp_ready`=0, all response fields stay stable. `rsp_valid` falls after a transfer with no new lookup. `rsp_hist` returns the history the lookup used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conf_thresh | input | CONF_W | Minimum confidence for an issued prediction |
| repl_mode | input | 2 | Victim policy: 0 age, 1 confidence, 2/3 combined |
| br_valid | input | 1 | A conditional branch resolved this cycle |
| br_taken | input | 1 | Outcome of that branch |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted this cycle |
| lk_pc | input | PC_W | PC of the indirect branch to predict |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A way matched |
| rsp_issue | output | 1 | Prediction is confident enough to use |
| rsp_target | output | TGT_W | Predicted target (0 on a miss) |
| rsp_hist | output | GHR_W | History used by this lookup |
| up_valid | input | 1 | Resolve update valid |
| up_pc | input | PC_W | PC of the resolved branch |
| up_hist | input | GHR_W | History returned with its lookup |
| up_target | input | TGT_W | Actual target |

## Verification
The bench builds the block with an 8-bit PC and target, a 4-bit history, four sets of two ways, and 2-bit confidence and age counters. With these sizes every PC can be swept for the empty-table check, and every history value can be folded into one fixed key. Every pairing of the four confidence levels with the four thresholds can also be covered. Two ways and three tags aimed at one set make each victim policy's choice visible at the ports, through which entry later misses. A long pseudo-random mix over a 32-PC pool then exercises evictions, overwrites and history changes under all four mode codes.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    REPL_AGE  = 2'd0,
    REPL_CONF = 2'd1,
    REPL_MIX  = 2'd2
  } repl_e;
endpackage

// File: rtl/itc_hist.sv
module itc_hist #(
  parameter int GHR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             din,
  output logic [GHR_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else if (shift) hist <= {hist[GHR_W-2:0], din};
  end
endmodule

// File: rtl/itc_match.sv
module itc_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tags[g] == tag);
  end

  always_comb begin
    hit = |eq;
    way = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (eq[i]) way = WAY_W'(i);
  end
endmodule

// File: rtl/itc_victim.sv
module itc_victim
  import itc_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int CONF_W = 2,
  parameter int AGE_W  = 3,
  parameter int WAY_W  = 2
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][CONF_W-1:0] conf,
  input  logic [WAYS-1:0][AGE_W-1:0]  age,
  input  logic [1:0]                  mode,
  output logic [WAY_W-1:0]            victim
);
  localparam int KEY_W = CONF_W + AGE_W;

  // larger key = better eviction candidate
  logic [WAYS-1:0][KEY_W-1:0] key;
  logic [KEY_W-1:0]           best;
  logic                       free;

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      case (repl_e'(mode))
        REPL_AGE:  key[i] = {{CONF_W{1'b0}}, age[i]};
        REPL_CONF: key[i] = {~conf[i], {AGE_W{1'b0}}};
        default:   key[i] = {~conf[i], age[i]};
      endcase
    end
  end

  always_comb begin
    free   = 1'b0;
    best   = key[0];
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!valid[i] && !free) begin
        free   = 1'b1;
        victim = WAY_W'(i);
      end
    end
    if (!free) begin
      for (int i = 1; i < WAYS; i++) begin
        if (key[i] > best) begin
          best   = key[i];
          victim = WAY_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/itc_predictor.sv
module itc_predictor
  import itc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int TGT_W  = 32,
  parameter int GHR_W  = 8,
  parameter int SET_W  = 6,
  parameter int WAYS   = 4,
  parameter int CONF_W = 2,
  parameter int AGE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CONF_W-1:0] conf_thresh,
  input  logic [1:0]        repl_mode,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_issue,
  output logic [TGT_W-1:0]  rsp_target,
  output logic [GHR_W-1:0]  rsp_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic [GHR_W-1:0]  up_hist,
  input  logic [TGT_W-1:0]  up_target
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = PC_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [AGE_W-1:0]  AGE_MAX  = '1;

  function automatic logic [PC_W-1:0] mix(input logic [PC_W-1:0] pc,
                                          input logic [GHR_W-1:0] h);
    return pc ^ PC_W'(h);
  endfunction

  // table storage, one packed row per set
  logic [WAYS-1:0]              v_q    [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q  [SETS];
  logic [WAYS-1:0][TGT_W-1:0]   tgt_q  [SETS];
  logic [WAYS-1:0][CONF_W-1:0]  conf_q [SETS];
  logic [WAYS-1:0][AGE_W-1:0]   age_q  [SETS];

  logic [GHR_W-1:0] ghr_q;

  itc_hist #(.GHR_W(GHR_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift(br_valid), .din(br_taken), .hist(ghr_q)
  );

  // ---------------- update path ----------------
  logic [PC_W-1:0]  u_key;
  logic [SET_W-1:0] u_set;
  logic [TAG_W-1:0] u_tag;
  logic             u_hit;
  logic [WAY_W-1:0] u_way, u_vic, u_sel;

  assign u_key = mix(up_pc, up_hist);
  assign u_set = u_key[SET_W-1:0];
  assign u_tag = u_key[PC_W-1:SET_W];

  itc_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_umatch (
    .valid(v_q[u_set]), .tags(tag_q[u_set]), .tag(u_tag), .hit(u_hit), .way(u_way)
  );

  itc_victim #(.WAYS(WAYS), .CONF_W(CONF_W), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_vsel (
    .valid(v_q[u_set]), .conf(conf_q[u_set]), .age(age_q[u_set]),
    .mode(repl_mode), .victim(u_vic)
  );

  assign u_sel = u_hit ? u_way : u_vic;

  logic [WAYS-1:0]             n_v;
  logic [WAYS-1:0][TAG_W-1:0]  n_tag;
  logic [WAYS-1:0][TGT_W-1:0]  n_tgt;
  logic [WAYS-1:0][CONF_W-1:0] n_conf;
  logic [WAYS-1:0][AGE_W-1:0]  n_age;

  always_comb begin
    n_v    = v_q[u_set];
    n_tag  = tag_q[u_set];
    n_tgt  = tgt_q[u_set];
    n_conf = conf_q[u_set];
    n_age  = age_q[u_set];
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == u_sel) begin
        n_v[i]   = 1'b1;
        n_tag[i] = u_tag;
        n_age[i] = '0;
        if (u_hit && (n_tgt[i] == up_target)) begin
          if (n_conf[i] != CONF_MAX) n_conf[i] = n_conf[i] + 1'b1;
        end else begin
          n_tgt[i]  = up_target;
          n_conf[i] = '0;
        end
      end else if (n_v[i] && (n_age[i] != AGE_MAX)) begin
        n_age[i] = n_age[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s]    <= '0;
        tag_q[s]  <= '0;
        tgt_q[s]  <= '0;
        conf_q[s] <= '0;
        age_q[s]  <= '0;
      end
    end else if (up_valid) begin
      v_q[u_set]    <= n_v;
      tag_q[u_set]  <= n_tag;
      tgt_q[u_set]  <= n_tgt;
      conf_q[u_set] <= n_conf;
      age_q[u_set]  <= n_age;
    end
  end

  // ---------------- lookup path ----------------
  logic [PC_W-1:0]             l_key;
  logic [SET_W-1:0]            l_set;
  logic [TAG_W-1:0]            l_tag;
  logic                        fwd;
  logic [WAYS-1:0]             r_v;
  logic [WAYS-1:0][TAG_W-1:0]  r_tag;
  logic [WAYS-1:0][TGT_W-1:0]  r_tgt;
  logic [WAYS-1:0][CONF_W-1:0] r_conf;
  logic                        l_hit, l_issue;
  logic [WAY_W-1:0]            l_way;
  logic [TGT_W-1:0]            l_tgt;

  assign l_key  = mix(lk_pc, ghr_q);
  assign l_set  = l_key[SET_W-1:0];
  assign l_tag  = l_key[PC_W-1:SET_W];
  assign fwd    = up_valid && (u_set == l_set);   // update wins the same set
  assign r_v    = fwd ? n_v    : v_q[l_set];
  assign r_tag  = fwd ? n_tag  : tag_q[l_set];
  assign r_tgt  = fwd ? n_tgt  : tgt_q[l_set];
  assign r_conf = fwd ? n_conf : conf_q[l_set];

  itc_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lmatch (
    .valid(r_v), .tags(r_tag), .tag(l_tag), .hit(l_hit), .way(l_way)
  );

  assign l_issue = l_hit && (r_conf[l_way] >= conf_thresh);
  assign l_tgt   = l_hit ? r_tgt[l_way] : '0;

  assign lk_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_issue  <= 1'b0;
      rsp_target <= '0;
      rsp_hist   <= '0;
    end else if (lk_valid && lk_ready) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= l_hit;
      rsp_issue  <= l_issue;
      rsp_target <= l_tgt;
      rsp_hist   <= ghr_q;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int TGT_W = 32,
  parameter int GHR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic             rsp_issue,
  input logic [TGT_W-1:0] rsp_target,
  input logic [GHR_W-1:0] rsp_hist,
  input logic             br_valid,
  input logic             br_taken,
  input logic [GHR_W-1:0] ghr
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !rsp_valid);

  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_issue && (rsp_target == '0));

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> ghr == {$past(ghr[GHR_W-2:0]), $past(br_taken)});

  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(ghr));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_issue)
                                && $stable(rsp_target) && $stable(rsp_hist));

  assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rsp_valid && (rsp_hist == $past(ghr)));
endmodule

bind itc_predictor itc_checker #(.TGT_W(TGT_W), .GHR_W(GHR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
  .rsp_issue(rsp_issue), .rsp_target(rsp_target), .rsp_hist(rsp_hist),
  .br_valid(br_valid), .br_taken(br_taken), .ghr(ghr_q)
);

// File: tb/sim_itc_predictor.sv
`timescale 1ns/1ps
module sim_itc_predictor;
  localparam int PW = 8, TW = 8, HW = 4, SW = 2, NW = 2, CW = 2, AW = 2;
  localparam int NS = 1 << SW, CMAX = (1 << CW) - 1, AMAX = (1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] conf_thresh = '0;
  logic [1:0] repl_mode = '0;
  logic br_valid = 0, br_taken = 0, lk_valid = 0, rsp_ready = 1, up_valid = 0;
  logic lk_ready, rsp_valid, rsp_hit, rsp_issue;
  logic [PW-1:0] lk_pc = '0, up_pc = '0;
  logic [TW-1:0] rsp_target, up_target = '0;
  logic [HW-1:0] rsp_hist, up_hist = '0;

  always #2.5 clk = ~clk;

  itc_predictor #(.PC_W(PW), .TGT_W(TW), .GHR_W(HW), .SET_W(SW), .WAYS(NW),
                  .CONF_W(CW), .AGE_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .conf_thresh(conf_thresh), .repl_mode(repl_mode),
    .br_valid(br_valid), .br_taken(br_taken), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_pc(lk_pc), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_issue(rsp_issue), .rsp_target(rsp_target), .rsp_hist(rsp_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_hist(up_hist), .up_target(up_target));

  int checks = 0, bad = 0;
  int mv[NS][NW], mtag[NS][NW], mtgt[NS][NW], mconf[NS][NW], mage[NS][NW];
  int mghr = 0, thr = 0, mode = 0;
  int e_hit, e_tgt, e_iss;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void mclear();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 0; mtag[s][w] = 0; mtgt[s][w] = 0; mconf[s][w] = 0; mage[s][w] = 0;
      end
    mghr = 0;
  endfunction

  // victim per R7..R10
  function automatic int mvictim(int s);
    int best, bw, k;
    for (int w = 0; w < NW; w++) if (mv[s][w] == 0) return w;
    best = -1; bw = 0;
    for (int w = 0; w < NW; w++) begin
      if (mode == 0) k = mage[s][w];
      else if (mode == 1) k = CMAX - mconf[s][w];
      else k = (CMAX - mconf[s][w]) * (AMAX + 1) + mage[s][w];
      if (k > best) begin best = k; bw = w; end
    end
    return bw;
  endfunction

  function automatic void mupdate(int pc, int h, int t);
    int key, s, tg, sel, hit;
    key = (pc ^ h) & ((1 << PW) - 1); s = key % NS; tg = key / NS;
    hit = 0; sel = 0;
    for (int w = 0; w < NW; w++)
      if (mv[s][w] != 0 && mtag[s][w] == tg && hit == 0) begin hit = 1; sel = w; end
    if (hit != 0) begin
      if (mtgt[s][sel] == t) begin
        if (mconf[s][sel] < CMAX) mconf[s][sel]++;
      end else begin
        mtgt[s][sel] = t; mconf[s][sel] = 0;
      end
    end else begin
      sel = mvictim(s);
      mv[s][sel] = 1; mtag[s][sel] = tg; mtgt[s][sel] = t; mconf[s][sel] = 0;
    end
    for (int w = 0; w < NW; w++)
      if (w == sel) mage[s][w] = 0;
      else if (mv[s][w] != 0 && mage[s][w] < AMAX) mage[s][w]++;
  endfunction

  function automatic void mpredict(int pc);
    int key, s, tg;
    key = (pc ^ mghr) & ((1 << PW) - 1); s = key % NS; tg = key / NS;
    e_hit = 0; e_tgt = 0; e_iss = 0;
    for (int w = 0; w < NW; w++)
      if (mv[s][w] != 0 && mtag[s][w] == tg) begin
        e_hit = 1; e_tgt = mtgt[s][w]; e_iss = (mconf[s][w] >= thr) ? 1 : 0;
      end
  endfunction

  task automatic check_rsp(string req, int eh);
    chk(req, "rsp_valid", int'(rsp_valid), 1);
    chk(req, "rsp_hit", int'(rsp_hit), e_hit);
    chk(req, "rsp_target", int'(rsp_target), e_tgt);
    chk(req, "rsp_issue", int'(rsp_issue), e_iss);
    chk(req, "rsp_hist", int'(rsp_hist), eh);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; lk_valid = 0; up_valid = 0; br_valid = 0; rsp_ready = 1;
    mclear();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic set_cfg(int t, int m);
    @(negedge clk);
    conf_thresh = CW'(t); repl_mode = 2'(m); thr = t; mode = m;
  endtask

  task automatic look(int pc, string req);
    int eh;
    @(negedge clk);
    lk_valid = 1; lk_pc = PW'(pc);
    mpredict(pc); eh = mghr;
    @(negedge clk);
    lk_valid = 0;
    check_rsp(req, eh);
  endtask

  task automatic upd(int pc, int t);
    @(negedge clk);
    up_valid = 1; up_pc = PW'(pc); up_hist = HW'(mghr); up_target = TW'(t);
    @(negedge clk);
    up_valid = 0;
    mupdate(pc, mghr, t);
  endtask

  task automatic br(int b);
    @(negedge clk);
    br_valid = 1; br_taken = b[0];
    @(negedge clk);
    br_valid = 0;
    mghr = ((mghr << 1) | (b & 1)) & ((1 << HW) - 1);
  endtask

  task automatic both(int upc, int t, int lpc, string req);
    int eh;
    @(negedge clk);
    up_valid = 1; up_pc = PW'(upc); up_hist = HW'(mghr); up_target = TW'(t);
    lk_valid = 1; lk_pc = PW'(lpc);
    mupdate(upc, mghr, t);
    mpredict(lpc); eh = mghr;
    @(negedge clk);
    up_valid = 0; lk_valid = 0;
    check_rsp(req, eh);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int a, b, c, d, seed, r;
    mclear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, empty table over every PC
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "lk_ready", int'(lk_ready), 1);
    for (int pc = 0; pc < (1 << PW); pc++) look(pc, "R1");

    // R6: history shifting, observed through rsp_hist
    for (int i = 0; i < 24; i++) begin
      br(((i * 5) >> 1) & 1);
      look(i, "R6");
    end

    // R2: every history value folded onto one fixed key
    do_reset();
    for (int h = 0; h < (1 << HW); h++) begin
      for (int k = HW - 1; k >= 0; k--) br((h >> k) & 1);
      upd('h5A ^ h, 16 + h);
      look('h5A ^ h, "R2");
      look('h5A, "R2");
    end

    // R3, R4, R5: one entry, every confidence level against every threshold
    do_reset();
    a = 'h10;
    look(a, "R3");
    upd(a, 'h33);
    for (int cl = 0; cl <= CMAX; cl++) begin
      for (int t = 0; t <= CMAX; t++) begin
        set_cfg(t, 0);
        look(a, "R4");
      end
      upd(a, 'h33);
    end
    set_cfg(CMAX, 0);
    look(a, "R5");
    upd(a, 'h44);
    set_cfg(1, 0);
    look(a, "R5");
    chk("R5", "overwritten target", int'(rsp_target), 'h44);
    chk("R5", "cleared confidence", int'(rsp_issue), 0);

    // R7/R8: age-based victim in set 0 (tags 1,2,3,7)
    a = 'h04; b = 'h08; c = 'h0C; d = 'h1C;
    do_reset(); set_cfg(0, 0);
    upd(a, 1); upd(a, 1); upd(b, 2);
    look(a, "R7"); look(b, "R7");
    upd(a, 1); upd(c, 3);
    look(b, "R8"); look(a, "R8"); look(c, "R8");

    // R9: confidence-based victim evicts the recent but unproven entry
    do_reset(); set_cfg(0, 1);
    upd(a, 1); upd(a, 1); upd(a, 1); upd(b, 2); upd(c, 3);
    look(b, "R9"); look(a, "R9"); look(c, "R9");

    // R10: combined policy, age breaks a confidence tie, confidence beats age
    do_reset(); set_cfg(0, 2);
    upd(a, 1); upd(b, 1); upd(a, 2); upd(c, 3);
    look(b, "R10"); look(a, "R10"); look(c, "R10");
    upd(a, 2); upd(a, 2); upd(c, 3); upd(d, 4);
    look(c, "R10"); look(a, "R10"); look(d, "R10");

    // R11: same-set update and lookup in one cycle
    do_reset(); set_cfg(1, 0);
    upd(a, 1); upd(a, 1);
    both(a, 9, a, "R11");
    both(b, 5, b, "R11");
    both('h01, 6, b, "R11");

    // R12: back-pressure on the response
    @(negedge clk);
    rsp_ready = 0; lk_valid = 1; lk_pc = PW'(a);
    mpredict(a); r = e_tgt;
    @(negedge clk);
    lk_pc = PW'(b);
    chk("R12", "lk_ready held", int'(lk_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12", "rsp_valid held", int'(rsp_valid), 1);
      chk("R12", "rsp_target held", int'(rsp_target), r);
      chk("R12", "lk_ready held", int'(lk_ready), 0);
    end
    rsp_ready = 1;
    #0.1;
    chk("R12", "lk_ready on release", int'(lk_ready), 1);
    mpredict(b);
    @(negedge clk);
    lk_valid = 0;
    check_rsp("R12", mghr);
    @(negedge clk);
    chk("R12", "rsp_valid drop", int'(rsp_valid), 0);

    // mixed pseudo-random traffic under every mode code
    seed = 32'h1234_5678;
    for (int m = 0; m < 4; m++) begin
      do_reset(); set_cfg(m, m);
      for (int i = 0; i < 250; i++) begin
        seed = seed * 1103515245 + 12345;
        r = (seed >>> 8) & 32'h00FF_FFFF;
        case (r % 4)
          0: br((r >> 3) & 1);
          1, 2: upd((r >> 4) & 31, 'h80 + ((r >> 10) & 3));
          default: look((r >> 4) & 31, (m < 2) ? "R8" : "R10");
        endcase
      end
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule